// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block turns a digitized supply-good flag into a processor reset line. While the flag is low the reset is held active, and it is applied without waiting for a clock edge. After the flag rises, the reset is released only when the flag has stayed high for a programmable number of clock cycles. If the flag drops during that interval, the count starts again from zero.

A watchdog is built in and watches a chip-select style activity line. When the watchdog is enabled and the reset is released, the line must show a falling edge within the selected timeout. If it stays high or stays low for that long, the block asserts reset. A reset caused by the watchdog lasts for the same hold interval and then releases, provided the supply is still good. A 2-bit input picks one of four timeout lengths, and a parameter sets the polarity of the reset output.

Top module: `sup_rst_seq`

## Requirements
- R1: While `supply_ok` is low, the reset output is active, from time zero on, and it is applied asynchronously.
- R2: After `supply_ok` rises, the reset releases exactly HOLD_CYC + SYNC_STAGES clock edges later, provided `supply_ok` stays high throughout.
- R3: A low pulse on `supply_ok` during the hold interval restarts the count, so the release is timed from the last rising edge of `supply_ok`.
- R4: With the watchdog enabled and the reset released, the reset asserts when no falling edge of `sel_i` has been counted for the selected timeout. The first count starts at the release, and the timeout applies whether `sel_i` is held high or held low.
- R5: A falling edge of `sel_i` is counted on the third clock edge after it occurs (two synchronizer stages and one edge stage), and it restarts the timeout from that edge. A rising edge of `sel_i` does not restart the timeout.
- R6: `wd_tsel` values 0, 1, 2 and 3 select timeouts of WD_CYC0, WD_CYC1, WD_CYC2 and WD_CYC3 cycles.
- R7: A reset caused by the watchdog lasts exactly HOLD_CYC cycles and then releases, provided `supply_ok` stays high.
- R8: With `wd_en` low, a released reset stays released for as long as `supply_ok` stays high, whatever `sel_i` does.
- R9: With ACTIVE_HIGH = 0 the output is low when active. With ACTIVE_HIGH = 1 it is high when active.
- R10: The watchdog does not count while the reset is active. Its timeout always starts at the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| supply_ok | input | 1 | Digitized supply-good flag; low means the supply is below the trip level |
| sel_i | input | 1 | Select activity line watched by the watchdog; its falling edges count as service |
| wd_en | input | 1 | Watchdog enable |
| wd_tsel | input | 2 | Watchdog timeout select, 0 to 3 |
| rst_o | output | 1 | Reset output; its polarity is set by ACTIVE_HIGH |

## Verification
When `supply_ok` rises between edges c and c+1, the release is due at edge c+HOLD_CYC+2. After a release at edge E with no service, the watchdog reset is due at edge E+T. A falling edge of `sel_i` driven after edge c restarts the timeout at edge c+3, so the next watchdog reset is due at c+3+T. The reset that follows then lasts exactly HOLD_CYC edges. The driver computes each of these edge numbers when it applies a stimulus and queues the expected level for the last cycle before the change and for the cycle of the change. The monitor samples both polarity variants on the falling clock edge of exactly that cycle, so an output that changes one cycle early or one cycle late is caught.

// File: rtl/sup_pkg.sv
package sup_pkg;

   // Supervisor state: reset held or reset released
   typedef enum logic {
      ST_HOLD = 1'b0,
      ST_RUN  = 1'b1
   } sup_state_e;

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/sup_rst_sync.sv
module sup_rst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic async_ok,
   output logic good_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sup_rst_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   // asserts at once when the flag drops, releases only through the chain
   always_ff @(posedge clk or negedge async_ok) begin
      if (!async_ok) chain_q <= '0;
      else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
   end

   assign good_o = chain_q[STAGES-1];

   // once released, the good level only ends through the asynchronous clear
   p_good_steady_r2: assert property (@(posedge clk) disable iff (!async_ok)
      good_o |=> good_o);

endmodule

// File: rtl/sup_edge_sync.sv
module sup_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic clr_n,
   input  logic sel_i,
   output logic fall_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sup_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         chain_q <= '1;
         last_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], sel_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign fall_o = last_q & ~chain_q[STAGES-1];

   // an edge yields a pulse of exactly one cycle
   p_single_pulse_r5: assert property (@(posedge clk) disable iff (!clr_n)
      fall_o |=> !fall_o);

endmodule

// File: rtl/sup_hold_timer.sv
module sup_hold_timer #(
   parameter int unsigned HOLD_CYC = 20_000_000
) (
   input  logic clk,
   input  logic clr_n,
   input  logic run_i,
   output logic done_o
);
   generate
      if (HOLD_CYC < 2) begin : g_bad_hold
         $error("sup_hold_timer: HOLD_CYC must be at least 2");
      end
   endgenerate

   localparam int unsigned    CW   = $clog2(HOLD_CYC);
   localparam logic [CW-1:0]  LAST = CW'(HOLD_CYC - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)                cnt_q <= '0;
      else if (!run_i || done_o) cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
   end

   assign done_o = run_i && (cnt_q == LAST);

   // the end of the interval is reported once, then counting restarts
   p_done_once_r2: assert property (@(posedge clk) disable iff (!clr_n)
      done_o |=> !done_o);

endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
   import sup_pkg::*;
#(
   parameter int unsigned WD_CYC0 = 15_000_000,
   parameter int unsigned WD_CYC1 = 60_000_000,
   parameter int unsigned WD_CYC2 = 100_000_000,
   parameter int unsigned WD_CYC3 = 140_000_000
) (
   input  logic       clk,
   input  logic       clr_n,
   input  logic       arm_i,
   input  logic       kick_i,
   input  logic [1:0] tsel_i,
   output logic       bite_o
);
   localparam int unsigned WD_MAX = max4(WD_CYC0, WD_CYC1, WD_CYC2, WD_CYC3);
   localparam int unsigned WW     = $clog2(WD_MAX + 1);

   generate
      if (WD_CYC0 < 2 || WD_CYC1 < 2 || WD_CYC2 < 2 || WD_CYC3 < 2) begin : g_bad_wd
         $error("sup_wdog: every timeout must be at least 2 cycles");
      end
   endgenerate

   logic [WW-1:0] lim;
   logic [WW-1:0] cnt_q;

   always_comb begin
      unique case (tsel_i)
         2'd0:    lim = WW'(WD_CYC0 - 1);
         2'd1:    lim = WW'(WD_CYC1 - 1);
         2'd2:    lim = WW'(WD_CYC2 - 1);
         default: lim = WW'(WD_CYC3 - 1);
      endcase
   end

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)                cnt_q <= '0;
      else if (!arm_i || kick_i) cnt_q <= '0;
      else if (!bite_o)          cnt_q <= cnt_q + 1'b1;
   end

   assign bite_o = arm_i && !kick_i && (cnt_q >= lim);

   // a serviced watchdog cannot expire in the following cycle
   p_kick_restarts_r5: assert property (@(posedge clk) disable iff (!clr_n)
      (kick_i && arm_i) |=> !bite_o);

endmodule

// File: rtl/sup_rst_seq.sv
module sup_rst_seq
   import sup_pkg::*;
#(
   parameter bit          ACTIVE_HIGH = 1'b0,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HOLD_CYC    = 20_000_000,
   parameter int unsigned WD_CYC0     = 15_000_000,
   parameter int unsigned WD_CYC1     = 60_000_000,
   parameter int unsigned WD_CYC2     = 100_000_000,
   parameter int unsigned WD_CYC3     = 140_000_000
) (
   input  logic       clk,
   input  logic       supply_ok,
   input  logic       sel_i,
   input  logic       wd_en,
   input  logic [1:0] wd_tsel,
   output logic       rst_o
);
   logic       core_ok;
   logic       kick;
   logic       hold_done;
   logic       wd_bite;
   logic       in_hold;
   sup_state_e state_q;

   sup_rst_sync #(.STAGES(SYNC_STAGES)) u_rsync (
      .clk      (clk),
      .async_ok (supply_ok),
      .good_o   (core_ok)
   );

   sup_edge_sync #(.STAGES(SYNC_STAGES)) u_esync (
      .clk    (clk),
      .clr_n  (core_ok),
      .sel_i  (sel_i),
      .fall_o (kick)
   );

   sup_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk    (clk),
      .clr_n  (core_ok),
      .run_i  (in_hold),
      .done_o (hold_done)
   );

   sup_wdog #(
      .WD_CYC0 (WD_CYC0),
      .WD_CYC1 (WD_CYC1),
      .WD_CYC2 (WD_CYC2),
      .WD_CYC3 (WD_CYC3)
   ) u_wdog (
      .clk    (clk),
      .clr_n  (core_ok),
      .arm_i  (wd_en && !in_hold),
      .kick_i (kick),
      .tsel_i (wd_tsel),
      .bite_o (wd_bite)
   );

   always_ff @(posedge clk or negedge core_ok) begin
      if (!core_ok) begin
         state_q <= ST_HOLD;
      end else begin
         unique case (state_q)
            ST_HOLD: if (hold_done) state_q <= ST_RUN;
            default: if (wd_bite)   state_q <= ST_HOLD;
         endcase
      end
   end

   assign in_hold = (state_q == ST_HOLD);

   generate
      if (ACTIVE_HIGH) begin : g_pol_high
         assign rst_o = in_hold;
      end else begin : g_pol_low
         assign rst_o = ~in_hold;
      end
   endgenerate

   // release only at the end of a full hold interval
   p_release_timed_r2: assert property (@(posedge clk) disable iff (!core_ok)
      $fell(in_hold) |-> $past(hold_done));

   // while the supply stays good, only an expired watchdog reasserts reset
   p_wd_cause_r4: assert property (@(posedge clk) disable iff (!core_ok)
      $rose(in_hold) |-> $past(wd_bite));

   // a watchdog reset is never a single-cycle glitch
   p_wd_reset_len_r7: assert property (@(posedge clk) disable iff (!core_ok)
      $rose(in_hold) |=> in_hold);

   // with the watchdog off, a release persists
   p_wd_off_r8: assert property (@(posedge clk) disable iff (!core_ok)
      (!wd_en && !in_hold) |=> !in_hold);

endmodule

// File: tb/sim_sup_rst_seq.sv
`timescale 1ns/1ps
module sim_sup_rst_seq;

   localparam int unsigned HC = 40;
   localparam int unsigned T0 = 16;
   localparam int unsigned T1 = 24;
   localparam int unsigned T2 = 48;
   localparam int unsigned T3 = 100;
   localparam int unsigned SS = 2;

   logic       clk = 1'b0;
   logic       supply_ok = 1'b0;
   logic       sel = 1'b1;
   logic       wd_en = 1'b0;
   logic [1:0] tsel = 2'd0;
   logic       rst_lo;
   logic       rst_hi;

   int cyc = 0;
   int n_cmp = 0;
   int n_bad = 0;

   typedef struct {
      int    at;
      bit    act;
      string tag;
   } exp_t;

   exp_t sb[$];
   exp_t cur;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sup_rst_seq #(.ACTIVE_HIGH(1'b0), .SYNC_STAGES(SS), .HOLD_CYC(HC),
      .WD_CYC0(T0), .WD_CYC1(T1), .WD_CYC2(T2), .WD_CYC3(T3)) u0 (
      .clk(clk), .supply_ok(supply_ok), .sel_i(sel), .wd_en(wd_en),
      .wd_tsel(tsel), .rst_o(rst_lo));

   sup_rst_seq #(.ACTIVE_HIGH(1'b1), .SYNC_STAGES(SS), .HOLD_CYC(HC),
      .WD_CYC0(T0), .WD_CYC1(T1), .WD_CYC2(T2), .WD_CYC3(T3)) u1 (
      .clk(clk), .supply_ok(supply_ok), .sel_i(sel), .wd_en(wd_en),
      .wd_tsel(tsel), .rst_o(rst_hi));

   // driver side: queue an expected reset level for a given cycle
   task automatic expect_at(input int at, input bit act, input string tag);
      exp_t e;
      int   i;
      e.at = at; e.act = act; e.tag = tag;
      i = 0;
      while (i < sb.size() && sb[i].at <= at) i++;
      sb.insert(i, e);
   endtask

   task automatic step(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         #1;
      end
   endtask

   // monitor side: compare both polarity variants in the due cycle
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].at == cyc) begin
         cur = sb.pop_front();
         n_cmp++;
         if (rst_lo !== !cur.act) begin
            n_bad++;
            $display("FAIL %s cyc %0d: active-low out actual %b expected %b",
                     cur.tag, cyc, rst_lo, !cur.act);
         end
         n_cmp++;
         if (rst_hi !== cur.act) begin
            n_bad++;
            $display("FAIL R9 (%s) cyc %0d: active-high out actual %b expected %b",
                     cur.tag, cyc, rst_hi, cur.act);
         end
      end
   end

   task automatic finish_run();
      while (sb.size() > 0) begin
         cur = sb.pop_front();
         n_cmp++;
         n_bad++;
         $display("FAIL %s: cycle %0d never sampled, actual none expected %b",
                  cur.tag, cur.at, cur.act);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual running expected done");
      finish_run();
   end

   initial begin
      int c0;
      int c1;
      int cl;
      // R1: reset state with the supply low from time zero
      expect_at(1, 1'b1, "R1");
      expect_at(3, 1'b1, "R1");
      step(4);

      // R2 and R8: release timing with the watchdog off
      c0 = cyc; supply_ok = 1'b1;
      expect_at(c0 + HC + SS - 1, 1'b1, "R2");
      expect_at(c0 + HC + SS,     1'b0, "R2");
      expect_at(c0 + 300,         1'b0, "R8");
      step(60);
      sel = 1'b0; step(20); sel = 1'b1;
      step(240);

      // R1: a supply drop forces reset without delay
      c0 = cyc; supply_ok = 1'b0;
      expect_at(c0 + 1, 1'b1, "R1");
      step(5);

      // R3: a glitch during the hold restarts the count
      c0 = cyc; supply_ok = 1'b1;
      step(20); supply_ok = 1'b0;
      step(2);  c1 = cyc; supply_ok = 1'b1;
      expect_at(c0 + HC + SS,     1'b1, "R3");
      expect_at(c1 + HC + SS - 1, 1'b1, "R3");
      expect_at(c1 + HC + SS,     1'b0, "R3");
      step(HC + 10);

      // R4, R6, R7, R10: watchdog on, select held high, timeout 0
      supply_ok = 1'b0; wd_en = 1'b1; tsel = 2'd0;
      step(3);
      c0 = cyc; supply_ok = 1'b1;
      expect_at(c0 + HC + SS + T0 - 1, 1'b0, "R10");
      expect_at(c0 + HC + SS + T0,     1'b1, "R4");
      expect_at(c0 + HC + SS + T0 + HC - 1, 1'b1, "R7");
      expect_at(c0 + HC + SS + T0 + HC,     1'b0, "R7");
      expect_at(c0 + HC + SS + 2*T0 + HC - 1, 1'b0, "R6");
      expect_at(c0 + HC + SS + 2*T0 + HC,     1'b1, "R6");
      step(2*HC + 2*T0 + 10);

      // R5 and R4: regular service with timeout 1, then select held low
      supply_ok = 1'b0; tsel = 2'd1;
      step(3);
      c0 = cyc; supply_ok = 1'b1;
      step(HC + SS + 3);
      cl = cyc;
      for (int k = 0; k < 10; k++) begin
         cl = cyc; sel = 1'b0;
         expect_at(cl + 5, 1'b0, "R5");
         step(5);
         if (k < 9) sel = 1'b1;
         step(5);
      end
      expect_at(cl + 3 + T1 - 1, 1'b0, "R4");
      expect_at(cl + 3 + T1,     1'b1, "R4");
      step(T1 + 10);

      // R6 and R5: timeout 2, a rising edge gives no service
      supply_ok = 1'b0; tsel = 2'd2;
      step(3);
      c0 = cyc; supply_ok = 1'b1;
      expect_at(c0 + HC + SS + T2 - 1, 1'b0, "R6");
      expect_at(c0 + HC + SS + T2,     1'b1, "R5");
      step(60);
      sel = 1'b1;
      step(HC + T2);

      step(5);
      finish_run();
   end

endmodule